// File: doc/BRIEF.md
# Packet Transmit Framer

This block turns payload bytes from a transmit FIFO into a serial bit stream ready for a modulator. A packet starts with a run of preamble bytes (`10101010`), continues with a 16-bit sync word that can optionally be repeated, then carries the bytes pulled from the FIFO, and may close with a 16-bit CRC. Every byte goes out MSB first. The modulator asks for bits one at a time through a strobe. The framer reads the FIFO through a show-ahead interface: data is valid whenever the FIFO is not empty, and a one-cycle read pulse removes the byte.

The packet length comes from one of three modes. In fixed mode it is a length value. In variable mode it is the first byte taken from the FIFO. In endless mode the packet continues until the mode is changed. An 8-bit byte counter wraps at 256. A packet longer than 255 bytes is therefore started in endless mode and switched to fixed mode near its end. The packet then closes when the wrapped counter equals the length value. If the FIFO runs dry in the middle of a packet, the framer enters an underflow state. It stays there until a flush command arrives.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset, `tx_active`, `done`, `underflow` and `fifo_rd` are all low.
- R2: A start command in idle begins the preamble. The preamble is `cfg_preamble_bytes` bytes of 0xAA, with a count of zero acting as one. If the FIFO is empty at the end of the last required preamble byte, more whole preamble bytes follow until the FIFO holds data at a byte end.
- R3: The sync word follows the preamble as the high byte of `cfg_sync`, then its low byte. With `cfg_sync_double` set, these two bytes are sent twice. The preamble count, sync value, sync doubling and CRC enable are captured at start. Changes to them while a packet is active have no effect on that packet.
- R4: With `cfg_len_mode` = 0 (fixed), exactly `cfg_length` bytes are taken from the FIFO and sent. Any further FIFO bytes are left unread. A length of one is the smallest packet.
- R5: With `cfg_len_mode` = 1 (variable), the first FIFO byte L is sent and then exactly L more bytes follow.
- R6: With `cfg_len_mode` = 2 or 3 (endless), bytes keep flowing. The mode and length inputs are live during a packet. After a switch to fixed mode, the packet ends when the 8-bit count of payload bytes (modulo 256) equals `cfg_length`. For example, 300 bytes end at a length of 44.
- R7: With CRC enabled, the block appends a CRC-16 over every byte taken from the FIFO, including the length byte. The polynomial is 0x8005, the register is seeded with 0xFFFF, bits are processed MSB first, and the high byte is sent first.
- R8: `tx_bit` shows the current bit and holds while `bit_req` is low. Each cycle with `bit_req` high while active moves to the next bit. `fifo_rd` pulses only in the cycle of a byte-ending `bit_req`, and `fifo_rdata` is taken in that same cycle.
- R9: `done` pulses for one cycle after the clock edge that consumes the final bit. `tx_active` falls at that same edge.
- R10: If a payload byte is needed while `fifo_empty` is high, `underflow` rises and `tx_active` falls. In that state no FIFO reads occur, even after data arrives, and start is ignored. Only `flush` clears it.
- R11: `flush` returns the block to idle from any state within one cycle, without a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet (idle only) |
| flush | input | 1 | Abort or leave underflow, go idle |
| cfg_len_mode | input | 2 | 0 fixed, 1 variable, 2/3 endless (live) |
| cfg_preamble_bytes | input | PRE_W | Preamble byte count |
| cfg_sync | input | 16 | Sync word |
| cfg_sync_double | input | 1 | Send sync word twice |
| cfg_crc_en | input | 1 | Append CRC-16 |
| cfg_length | input | LEN_W | Fixed length / end-match value (live) |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_rdata | input | 8 | Show-ahead FIFO head byte |
| fifo_rd | output | 1 | Pop FIFO head |
| bit_req | input | 1 | Modulator takes current bit |
| tx_bit | output | 1 | Current serial bit |
| tx_active | output | 1 | Packet in progress |
| done | output | 1 | Packet finished pulse |
| underflow | output | 1 | Sticky FIFO underflow state |

## Verification
The bench goes after four corner cases. The first is the moment data appears during the preamble. A framer that checked the FIFO mid-byte or ignored it would send a cut preamble byte or start the sync early. The second is a 300-byte packet switched from endless to fixed mode. A counter that did not wrap, or an end test done only at the switch, would stop at byte 44 or never stop. The third covers the length byte in variable mode and its inclusion in the CRC. Getting this wrong shifts the end by one byte or corrupts the checksum. The fourth covers underflow and flush: a non-sticky underflow would resume and drain the late bytes, while a flush that raised `done` would report a packet that never completed.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [7:0] PRE_PATTERN = 8'hAA;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SYNC, PH_DATA, PH_CRC, PH_UNDER
  } ph_t;

  typedef enum logic [1:0] {
    LM_FIXED = 2'd0, LM_VAR = 2'd1, LM_ENDLESS = 2'd2, LM_ENDLESS_ALT = 2'd3
  } lmode_t;

  // One byte through the CRC-16 register, MSB first
  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/pkt_tx_shreg.sv
module pkt_tx_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         bit_out,
  output logic         at_last
);
  localparam int IW = $clog2(W);
  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= din;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      idx_q <= idx_q + IW'(1);
    end
  end

  assign bit_out = sh_q[W-1];
  assign at_last = (idx_q == IW'(W - 1));
endmodule

// File: rtl/pkt_tx_crc.sv
module pkt_tx_crc
  import pkt_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (init) crc_q <= CRC_SEED;
    else if (upd)  crc_q <= crc16_next(crc_q, din);
  end

  assign crc = crc_q;
endmodule

// File: rtl/pkt_tx_bytecnt.sv
module pkt_tx_bytecnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_plus
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_plus;
  end

  assign cnt      = cnt_q;
  assign cnt_plus = cnt_q + W'(1);
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import pkt_tx_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             flush,
  input  logic [1:0]       cfg_len_mode,
  input  logic [PRE_W-1:0] cfg_preamble_bytes,
  input  logic [15:0]      cfg_sync,
  input  logic             cfg_sync_double,
  input  logic             cfg_crc_en,
  input  logic [LEN_W-1:0] cfg_length,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_rdata,
  output logic             fifo_rd,
  input  logic             bit_req,
  output logic             tx_bit,
  output logic             tx_active,
  output logic             done,
  output logic             underflow
);
  ph_t st_q, st_d;
  logic [PRE_W-1:0] pre_n_q, pre_cnt_q;
  logic [15:0]      sync_q;
  logic             dbl_q, crc_en_q;
  logic [1:0]       sync_idx_q;
  logic             crc_idx_q, first_q, last_q, done_q;
  logic [LEN_W-1:0] vlen_q;

  // Named internal events
  logic sh_last, byte_end, bit_adv, accept, ld, pop, fin, want_byte;
  logic [7:0] ld_val;
  logic [15:0] crc_val;
  logic [LEN_W-1:0] cnt, cnt_plus;
  logic pre_done, sync_last, len_byte, last_next;

  assign tx_active = (st_q == PH_PRE) || (st_q == PH_SYNC) ||
                     (st_q == PH_DATA) || (st_q == PH_CRC);
  assign underflow = (st_q == PH_UNDER);
  assign byte_end  = tx_active && bit_req && sh_last;
  assign bit_adv   = tx_active && bit_req && !sh_last;
  assign accept    = (st_q == PH_IDLE) && start && !flush;
  assign pre_done  = (pre_cnt_q + PRE_W'(1)) >= pre_n_q;
  assign sync_last = dbl_q ? (sync_idx_q == 2'd3) : (sync_idx_q == 2'd1);
  assign len_byte  = first_q && (lmode_t'(cfg_len_mode) == LM_VAR);

  always_comb begin
    case (lmode_t'(cfg_len_mode))
      LM_FIXED: last_next = (cnt_plus == cfg_length);
      LM_VAR:   last_next = !len_byte && (cnt_plus == vlen_q);
      default:  last_next = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q; ld = 1'b0; ld_val = PRE_PATTERN;
    pop = 1'b0; fin = 1'b0; want_byte = 1'b0;
    case (st_q)
      PH_IDLE: if (start) begin st_d = PH_PRE; ld = 1'b1; end
      PH_PRE: if (byte_end) begin
        ld = 1'b1;
        if (pre_done && !fifo_empty) begin st_d = PH_SYNC; ld_val = sync_q[15:8]; end
      end
      PH_SYNC: if (byte_end) begin
        if (sync_last) want_byte = 1'b1;
        else begin ld = 1'b1; ld_val = sync_idx_q[0] ? sync_q[15:8] : sync_q[7:0]; end
      end
      PH_DATA: if (byte_end) begin
        if (!last_q) want_byte = 1'b1;
        else if (crc_en_q) begin st_d = PH_CRC; ld = 1'b1; ld_val = crc_val[15:8]; end
        else fin = 1'b1;
      end
      PH_CRC: if (byte_end) begin
        if (!crc_idx_q) begin ld = 1'b1; ld_val = crc_val[7:0]; end
        else fin = 1'b1;
      end
      default: ;
    endcase
    if (want_byte) begin
      if (fifo_empty) st_d = PH_UNDER;
      else begin pop = 1'b1; ld = 1'b1; ld_val = fifo_rdata; st_d = PH_DATA; end
    end
    if (fin) st_d = PH_IDLE;
    if (flush) begin st_d = PH_IDLE; ld = 1'b0; pop = 1'b0; fin = 1'b0; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE; pre_n_q <= '0; pre_cnt_q <= '0; sync_q <= '0;
      dbl_q <= 1'b0; crc_en_q <= 1'b0; sync_idx_q <= '0; crc_idx_q <= 1'b0;
      first_q <= 1'b0; last_q <= 1'b0; vlen_q <= '0; done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (accept) begin
        pre_n_q <= cfg_preamble_bytes; pre_cnt_q <= '0; sync_q <= cfg_sync;
        dbl_q <= cfg_sync_double; crc_en_q <= cfg_crc_en; sync_idx_q <= '0;
        crc_idx_q <= 1'b0; first_q <= 1'b1; last_q <= 1'b0;
      end
      if (st_q == PH_PRE && byte_end && !pre_done) pre_cnt_q <= pre_cnt_q + PRE_W'(1);
      if (st_q == PH_SYNC && byte_end) sync_idx_q <= sync_idx_q + 2'd1;
      if (st_q == PH_CRC && byte_end) crc_idx_q <= 1'b1;
      if (pop) begin
        first_q <= 1'b0;
        last_q  <= last_next;
        if (len_byte) vlen_q <= LEN_W'(fifo_rdata);
      end
    end
  end

  pkt_tx_shreg #(.W(BYTE_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(ld), .din(ld_val), .shift(bit_adv),
    .bit_out(tx_bit), .at_last(sh_last)
  );

  pkt_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(accept), .upd(pop), .din(fifo_rdata), .crc(crc_val)
  );

  pkt_tx_bytecnt #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(pop && !len_byte),
    .cnt(cnt), .cnt_plus(cnt_plus)
  );

  assign fifo_rd = pop;
  assign done    = done_q;

  logic unused_cnt;
  assign unused_cnt = ^cnt;
endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        flush,
  input logic        bit_req,
  input logic        fifo_rd,
  input logic        tx_active,
  input logic        tx_bit,
  input logic        done,
  input logic        underflow,
  input logic        byte_end,
  input logic [15:0] sync_lat
);
  // R10
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !flush |=> underflow);
  // R10
  underflow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> !tx_active && !fifo_rd);
  // R11
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !tx_active && !underflow && !done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_active);
  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active && !bit_req && !flush |=> tx_active && $stable(tx_bit));
  // R8
  pop_at_byte_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> byte_end && bit_req);
  // R3
  sync_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> !tx_active || $stable(sync_lat));
  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !tx_active && !underflow && !flush |=> tx_active);
endmodule

bind pkt_tx_framer pkt_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .flush(flush), .bit_req(bit_req),
  .fifo_rd(fifo_rd), .tx_active(tx_active), .tx_bit(tx_bit), .done(done),
  .underflow(underflow), .byte_end(byte_end), .sync_lat(sync_q)
);

// File: tb/pkt_tx_framer_tb.sv
`timescale 1ns/1ps
module pkt_tx_framer_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, flush = 1'b0;
  logic [1:0] cfg_len_mode = 2'd0;
  logic [3:0] cfg_preamble_bytes = 4'd2;
  logic [15:0] cfg_sync = 16'hD391;
  logic cfg_sync_double = 1'b0, cfg_crc_en = 1'b0;
  logic [7:0] cfg_length = 8'd1;
  logic fifo_empty = 1'b1;
  logic [7:0] fifo_rdata = 8'h00;
  logic bit_req = 1'b0;
  logic fifo_rd, tx_bit, tx_active, done, underflow;

  logic [7:0] fifo_q[$];
  bit exp_q[$];
  int n_tests = 0, n_fail = 0, bits_sent = 0;
  string cur_req = "R8";

  always #4 clk = ~clk;

  pkt_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .flush(flush),
    .cfg_len_mode(cfg_len_mode), .cfg_preamble_bytes(cfg_preamble_bytes),
    .cfg_sync(cfg_sync), .cfg_sync_double(cfg_sync_double), .cfg_crc_en(cfg_crc_en),
    .cfg_length(cfg_length), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .bit_req(bit_req), .tx_bit(tx_bit), .tx_active(tx_active),
    .done(done), .underflow(underflow)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(logic [15:0] c, logic [7:0] d);
    c = c ^ {d, 8'h00};
    repeat (8) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    return c;
  endfunction

  task automatic push_byte(logic [7:0] b);
    for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
  endtask

  task automatic expect_frame(int pre, logic [15:0] sy, bit dbl, bit crc, logic [7:0] body[$]);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < pre; i++) push_byte(8'hAA);
    for (int r = 0; r < (dbl ? 2 : 1); r++) begin push_byte(sy[15:8]); push_byte(sy[7:0]); end
    foreach (body[i]) begin push_byte(body[i]); c = crc_ref(c, body[i]); end
    if (crc) begin push_byte(c[15:8]); push_byte(c[7:0]); end
  endtask

  // One clock: drive at the falling edge, check 1 ns later, note FIFO pop at the rising edge
  task automatic tick(bit req);
    bit pop_seen;
    bit_req = req;
    fifo_empty = (fifo_q.size() == 0);
    fifo_rdata = fifo_empty ? 8'h00 : fifo_q[0];
    #1;
    if (req && exp_q.size() > 0) begin
      bit e = exp_q.pop_front();
      chk(tx_active, "R8", tx_active, 1);
      chk(tx_bit == e, cur_req, tx_bit, e);
      bits_sent++;
    end
    pop_seen = fifo_rd;
    @(posedge clk);
    if (pop_seen && fifo_q.size() > 0) void'(fifo_q.pop_front());
    @(negedge clk);
  endtask

  task automatic begin_pkt();
    start = 1'b1; tick(0); start = 1'b0; bits_sent = 0;
  endtask

  task automatic run(int push_at, logic [7:0] late[$], int hook_at, int hook_kind,
                     bit gaps, bit expect_done);
    int guard = 0;
    bit pushed = 0, hooked = 0;
    while (exp_q.size() > 0 && guard < 20000) begin
      if (!pushed && push_at >= 0 && bits_sent == push_at) begin
        foreach (late[i]) fifo_q.push_back(late[i]);
        pushed = 1;
      end
      if (!hooked && hook_at >= 0 && bits_sent == hook_at) begin
        hooked = 1;
        if (hook_kind == 1) cfg_len_mode = 2'd0;
        if (hook_kind == 2) begin
          cfg_sync = ~cfg_sync; cfg_crc_en = ~cfg_crc_en;
          cfg_sync_double = ~cfg_sync_double; cfg_preamble_bytes = 4'd9;
        end
        if (hook_kind == 3) begin
          flush = 1'b1; tick(0); flush = 1'b0; exp_q.delete();
        end
      end
      if (exp_q.size() > 0) tick(gaps ? (guard % 3 != 0) : 1'b1);
      guard++;
    end
    chk(guard < 20000, cur_req, guard, 0);
    if (expect_done) begin
      chk(done == 1'b1, "R9", done, 1);
      chk(tx_active == 1'b0, "R9", tx_active, 0);
      tick(0);
      chk(done == 1'b0, "R9", done, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] body[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_active, "R1", tx_active, 0);
    chk(!done, "R1", done, 0);
    chk(!underflow, "R1", underflow, 0);
    chk(!fifo_rd, "R1", fifo_rd, 0);

    // R4 fixed length, one extra byte must stay in the FIFO
    cur_req = "R4";
    cfg_len_mode = 2'd0; cfg_length = 8'd5; cfg_preamble_bytes = 4'd2;
    cfg_sync = 16'hD391; cfg_sync_double = 0; cfg_crc_en = 0;
    body = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    foreach (body[i]) fifo_q.push_back(body[i]);
    fifo_q.push_back(8'h66);
    expect_frame(2, 16'hD391, 0, 0, body);
    begin_pkt();
    run(-1, '{}, -1, 0, 0, 1);
    chk(fifo_q.size() == 1, "R4", fifo_q.size(), 1);
    fifo_q.delete();

    // R5 variable length with doubled sync (R3) and CRC incl. length byte (R7), gapped strobes
    cur_req = "R5";
    cfg_len_mode = 2'd1; cfg_preamble_bytes = 4'd3; cfg_sync = 16'h1F35;
    cfg_sync_double = 1; cfg_crc_en = 1;
    body = '{8'h04, 8'hA0, 8'hA1, 8'hA2, 8'hA3};
    foreach (body[i]) fifo_q.push_back(body[i]);
    fifo_q.push_back(8'h5A);
    expect_frame(3, 16'h1F35, 1, 1, body);
    begin_pkt();
    run(-1, '{}, -1, 0, 1, 1);
    chk(fifo_q.size() == 1, "R5", fifo_q.size(), 1);
    fifo_q.delete();

    // R2 preamble stretches until data arrives: data pushed after 2 bytes gives 3 preamble bytes
    cur_req = "R2";
    cfg_len_mode = 2'd0; cfg_length = 8'd3; cfg_preamble_bytes = 4'd1;
    cfg_sync = 16'hB00C; cfg_sync_double = 0; cfg_crc_en = 1;
    body = '{8'hC1, 8'hC2, 8'hC3};
    expect_frame(3, 16'hB00C, 0, 1, body);
    begin_pkt();
    run(16, body, -1, 0, 0, 1);

    // R3 configuration changes mid-packet are ignored
    cur_req = "R3";
    cfg_len_mode = 2'd0; cfg_length = 8'd4; cfg_preamble_bytes = 4'd2;
    cfg_sync = 16'h7E81; cfg_sync_double = 1; cfg_crc_en = 1;
    body = '{8'h00, 8'hFF, 8'h0F, 8'hF0};
    foreach (body[i]) fifo_q.push_back(body[i]);
    expect_frame(2, 16'h7E81, 1, 1, body);
    begin_pkt();
    run(-1, '{}, 40, 2, 0, 1);
    cfg_sync_double = 0; cfg_crc_en = 1; cfg_preamble_bytes = 4'd4;

    // R6 300-byte packet: endless, then fixed with length 44 once past byte 100; CRC on (R7)
    cur_req = "R6";
    cfg_len_mode = 2'd2; cfg_length = 8'd44; cfg_sync = 16'h2DD4;
    body.delete();
    for (int i = 0; i < 300; i++) body.push_back(8'((i * 7 + 3) & 255));
    foreach (body[i]) fifo_q.push_back(body[i]);
    expect_frame(4, 16'h2DD4, 0, 1, body);
    begin_pkt();
    run(-1, '{}, (4 + 2 + 100) * 8, 1, 0, 1);
    chk(fifo_q.size() == 0, "R6", fifo_q.size(), 0);
    fifo_q.delete();

    // R10 underflow: six bytes wanted, three available
    cur_req = "R10";
    cfg_len_mode = 2'd0; cfg_length = 8'd6; cfg_preamble_bytes = 4'd1; cfg_crc_en = 0;
    body = '{8'h91, 8'h92, 8'h93};
    foreach (body[i]) fifo_q.push_back(body[i]);
    expect_frame(1, 16'h2DD4, 0, 0, body);
    begin_pkt();
    run(-1, '{}, -1, 0, 0, 0);
    chk(underflow == 1'b1, "R10", underflow, 1);
    chk(tx_active == 1'b0, "R10", tx_active, 0);
    chk(done == 1'b0, "R10", done, 0);
    fifo_q.push_back(8'h94); fifo_q.push_back(8'h95); fifo_q.push_back(8'h96);
    start = 1'b1; tick(1); start = 1'b0;
    for (int i = 0; i < 10; i++) tick(1);
    chk(fifo_q.size() == 3, "R10", fifo_q.size(), 3);
    chk(underflow == 1'b1, "R10", underflow, 1);
    chk(tx_active == 1'b0, "R10", tx_active, 0);
    flush = 1'b1; tick(0); flush = 1'b0;
    chk(underflow == 1'b0, "R10", underflow, 0);
    chk(tx_active == 1'b0, "R10", tx_active, 0);
    fifo_q.delete();

    // R11 flush in mid-packet
    cur_req = "R11";
    cfg_length = 8'd4; cfg_preamble_bytes = 4'd2;
    body = '{8'h01, 8'h02, 8'h03, 8'h04};
    foreach (body[i]) fifo_q.push_back(body[i]);
    expect_frame(2, 16'h2DD4, 0, 0, body);
    begin_pkt();
    run(-1, '{}, 20, 3, 0, 0);
    chk(tx_active == 1'b0, "R11", tx_active, 0);
    chk(done == 1'b0, "R11", done, 0);
    tick(0);
    chk(done == 1'b0, "R11", done, 0);
    fifo_q.delete();

    // R4 minimum one-byte packet after a flush, with CRC (R7)
    cur_req = "R7";
    cfg_length = 8'd1; cfg_preamble_bytes = 4'd1; cfg_crc_en = 1;
    body = '{8'h3C};
    fifo_q.push_back(8'h3C);
    expect_frame(1, 16'h2DD4, 0, 1, body);
    begin_pkt();
    run(-1, '{}, -1, 0, 1, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule